// File: doc/BRIEF.md
# Secondary Bus Mode Detection Sequencer

After reset, this block works out which operating mode the secondary bus can run in. It watches a capability sense line that the attached devices can leave floating, pull low through a resistor, or tie hard to ground. It also drives an enable that switches a strong external pull-up onto that line. From the answers it settles on one of four modes: conventional PCI, PCI-X 66, PCI-X 100 or PCI-X 133. It then raises a done flag.

The probe runs in two stages. The first sample is taken with the strong pull-up switched off. A high reading means every device can run at the top speed class. In that case a frequency range select input picks between the two upper ranges. A low reading can mean either of two things: a device pulling the line low through a resistor, or a device tying it to ground. To tell these apart, the block turns the strong pull-up on and samples again. Both inputs pass through a two-flop synchronizer. No sample is taken until a settle interval has elapsed after reset release and after the pull-up enable changes.

A PLL-bypass output goes high only when the result is conventional PCI. In that mode the incoming bus clock is used directly, and 33 MHz and 66 MHz operation are not told apart. The result stays fixed until the next reset.

Top module: `bmd_mode_detect`

## Requirements
- R1: While reset is asserted (rst_n low), strong_pu_en is 0, done is 0, mode is 2'b00 and pll_bypass is 0.
- R2: After reset release, the first sense sample is taken with strong_pu_en at 0, no earlier than SETTLE_CYCLES clock edges after release. When that sample is high, done rises between SETTLE_CYCLES+1 and SETTLE_CYCLES+4 edges after release.
- R3: When the first sample is low, strong_pu_en goes to 1 between SETTLE_CYCLES+1 and SETTLE_CYCLES+4 edges after release. The second sample follows a further settle interval, so done rises between 2*SETTLE_CYCLES+1 and 2*SETTLE_CYCLES+6 edges after release.
- R4: When the second sample is still low, mode becomes 2'b00 (conventional PCI) and strong_pu_en stays at 1.
- R5: When the second sample is high, mode becomes 2'b01 (PCI-X 66) and strong_pu_en stays at 1.
- R6: When the first sample is high and the range select input is high, mode becomes 2'b10 (PCI-X 100) and strong_pu_en stays at 0.
- R7: When the first sample is high and the range select input is low, mode becomes 2'b11 (PCI-X 133) and strong_pu_en stays at 0.
- R8: pll_bypass is 1 exactly when done is 1 and mode is 2'b00. It is 0 before done.
- R9: Once done is 1, changes on the sense and select inputs have no effect. done, mode and strong_pu_en hold their values until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sense_in | input | 1 | Capability sense line from the bus (asynchronous) |
| range_sel_in | input | 1 | Frequency range select: 1 selects the 100 MHz class, 0 selects the 133 MHz class (asynchronous) |
| strong_pu_en | output | 1 | Enable for the strong external pull-up on the sense line |
| mode | output | 2 | Resolved mode: 00 conventional, 01 PCI-X 66, 10 PCI-X 100, 11 PCI-X 133 |
| done | output | 1 | Mode is valid |
| pll_bypass | output | 1 | Bypass the PLL and use the bus clock directly (conventional mode only) |

## Verification
The bench models the sense line as a function of the pull-up enable. A resistor-pulled line follows the enable, while a grounded line stays low. A design that never enables the pull-up, or that samples before the line has settled, would therefore report conventional PCI for a bus that can run PCI-X 66. For every case, the bench times done and the rise of the pull-up enable against the settle windows. A sequencer that skipped the second settle interval would finish too early, and one that skipped the first would finish too early in the one-stage cases. After done, the bench inverts both inputs for a while and checks that the result and the enable hold. The cases then run again in a different order, which shows that reset fully re-arms the probe and that nothing carries over from the previous result.

// File: rtl/bmd_pkg.sv
// Package: shared encodings for the secondary bus mode detector.
// Assumes: mode encoding is fixed and decoded by neighbouring logic.
package bmd_pkg;

    typedef enum logic [1:0] {
        MODE_CONV = 2'b00,
        MODE_X66  = 2'b01,
        MODE_X100 = 2'b10,
        MODE_X133 = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_PROBE_WEAK   = 2'b00,
        ST_PROBE_STRONG = 2'b01,
        ST_LOCKED       = 2'b10
    } probe_state_e;

endpackage

// File: rtl/bmd_sync.sv
// Module: multi-bit flop-chain synchronizer.
// Does: brings WIDTH asynchronous, slowly changing levels into the clk domain.
// Assumes: each bit is a quasi-static level; bits are not required to arrive
// together, since the sequencer waits a settle interval before using them.
module bmd_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] pipe [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw asynchronous levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= d_in;
                end
            end else begin : g_next
                // Pass the level one flop further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe[g] <= '0;
                    else        pipe[g] <= pipe[g-1];
                end
            end
        end
    endgenerate

    assign d_out = pipe[STAGES-1];

endmodule

// File: rtl/bmd_settle_timer.sv
// Module: settle interval timer.
// Does: counts clock edges since reset or since the last restart, saturating
// at SETTLE_CYCLES, and flags when the interval has elapsed.
// Assumes: restart is a single-cycle pulse from the sequencer.
module bmd_settle_timer #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);

    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

    logic [CW-1:0] count_q;

    // Saturating edge counter, cleared on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                count_q <= '0;
        else if (restart)          count_q <= '0;
        else if (count_q != LIMIT) count_q <= count_q + 1'b1;
    end

    assign expired = (count_q == LIMIT);

endmodule

// File: rtl/bmd_probe_fsm.sv
// Module: two-stage probe sequencer.
// Does: takes the first sense sample with the pull-up off. On low, enables
// the pull-up, restarts the settle timer and resamples. Then latches the
// resolved mode and done until reset.
// Assumes: sense_s and range_s are already synchronized; settled comes from
// a timer that this block restarts whenever it changes pu_en.
module bmd_probe_fsm
    import bmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       settled,
    input  logic       sense_s,
    input  logic       range_s,
    output logic       restart,
    output logic       pu_en,
    output logic [1:0] mode,
    output logic       done
);

    probe_state_e state_q;
    bus_mode_e    mode_q;
    logic         pu_q;
    logic         done_q;

    // Restart the timer on the very edge that switches the pull-up on.
    always_comb begin
        restart = (state_q == ST_PROBE_WEAK) && settled && !sense_s;
    end

    // Sequence the probe stages and latch the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PROBE_WEAK;
            mode_q  <= MODE_CONV;
            pu_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_PROBE_WEAK: begin
                    if (settled) begin
                        if (sense_s) begin
                            mode_q  <= range_s ? MODE_X100 : MODE_X133;
                            done_q  <= 1'b1;
                            state_q <= ST_LOCKED;
                        end else begin
                            pu_q    <= 1'b1;
                            state_q <= ST_PROBE_STRONG;
                        end
                    end
                end
                ST_PROBE_STRONG: begin
                    if (settled) begin
                        mode_q  <= sense_s ? MODE_X66 : MODE_CONV;
                        done_q  <= 1'b1;
                        state_q <= ST_LOCKED;
                    end
                end
                default: begin
                    state_q <= ST_LOCKED;
                end
            endcase
        end
    end

    assign pu_en = pu_q;
    assign mode  = mode_q;
    assign done  = done_q;

endmodule

// File: rtl/bmd_mode_detect.sv
// Module: secondary bus mode detector (top).
// Does: synchronizes the sense and range select inputs, runs the two-stage
// pull-up probe with a settle interval before each sample, and reports the
// mode, done and PLL bypass.
// Assumes: synchronous active-low reset; the inputs are static levels during
// the probe except for the response of the sense line to strong_pu_en.
module bmd_mode_detect
    import bmd_pkg::*;
#(
    parameter int SETTLE_CYCLES = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sense_in,
    input  logic       range_sel_in,
    output logic       strong_pu_en,
    output logic [1:0] mode,
    output logic       done,
    output logic       pll_bypass
);

    logic [1:0] raw_in;
    logic [1:0] sync_out;
    logic       settled;
    logic       restart;

    assign raw_in = {range_sel_in, sense_in};

    bmd_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (sync_out)
    );

    bmd_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expired (settled)
    );

    bmd_probe_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .settled (settled),
        .sense_s (sync_out[0]),
        .range_s (sync_out[1]),
        .restart (restart),
        .pu_en   (strong_pu_en),
        .mode    (mode),
        .done    (done)
    );

    // The PLL is bypassed only for a resolved conventional-mode bus.
    always_comb begin
        pll_bypass = done && (mode == MODE_CONV);
    end

endmodule

// File: rtl/bmd_mode_detect_chk.sv
// Module: property checker for the mode detector, bound to the top.
// Does: checks the settle window, pull-up usage, result stability and
// PLL bypass consistency at the top ports.
// Assumes: SETTLE_CYCLES matches the bound instance.
module bmd_mode_detect_chk #(
    parameter int SETTLE_CYCLES = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       strong_pu_en,
    input logic [1:0] mode,
    input logic       done,
    input logic       pll_bypass
);

    localparam int CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

    logic [CW-1:0] since_rst;

    // Count edges since reset release, saturating at the settle limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  since_rst <= '0;
        else if (since_rst != LIMIT) since_rst <= since_rst + 1'b1;
    end

    // R2: nothing is decided inside the first settle window.
    assert_no_early_decision_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < LIMIT) |-> (!done && !strong_pu_en));

    // R3: the pull-up is switched on only while the probe is still running.
    assert_pu_before_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strong_pu_en) |-> !done);

    // R4, R5: lower modes come only from the strong-pull-up stage.
    assert_lower_modes_use_pu_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode[1]) |-> strong_pu_en);

    // R6, R7: upper modes never engage the strong pull-up.
    assert_upper_modes_no_pu_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode[1]) |-> !strong_pu_en);

    // R8: bypass only accompanies a resolved conventional mode.
    assert_bypass_implies_conv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pll_bypass |-> (done && mode == 2'b00));

    // R8: a resolved conventional mode always bypasses.
    assert_conv_implies_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode == 2'b00) |-> pll_bypass);

    // R9: the result is frozen once done.
    assert_result_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(mode) && $stable(strong_pu_en)));

endmodule

bind bmd_mode_detect bmd_mode_detect_chk #(
    .SETTLE_CYCLES (SETTLE_CYCLES)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .strong_pu_en (strong_pu_en),
    .mode         (mode),
    .done         (done),
    .pll_bypass   (pll_bypass)
);

// File: tb/test_bmd_mode_detect.sv
`timescale 1ns/1ps
// Bench: scoreboard for the mode detector. The driver pushes the expected
// result of each bus population; the monitor pops it when done rises.
module test_bmd_mode_detect;

    localparam int SETTLE = 16;

    // Bus populations: 0 grounded line, 1 resistor-pulled line, 2 fast bus
    // with select high, 3 fast bus with select low.
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] env_kind = 2'd0;
    logic       flip = 1'b0;
    logic       sense_in;
    logic       range_sel_in;
    logic       strong_pu_en;
    logic [1:0] mode;
    logic       done;
    logic       pll_bypass;

    typedef struct {
        logic [1:0] mode;
        logic       pu;
        int         lo;
        int         hi;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   pu_rise = -1;
    logic got = 1'b0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    // Line model: a resistor-pulled line follows the strong pull-up.
    always_comb begin
        case (env_kind)
            2'd0:    sense_in = flip;
            2'd1:    sense_in = strong_pu_en ^ flip;
            default: sense_in = ~flip;
        endcase
        range_sel_in = (env_kind == 2'd2) ^ flip;
    end

    bmd_mode_detect #(.SETTLE_CYCLES(SETTLE)) i_bmd_mode_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .sense_in     (sense_in),
        .range_sel_in (range_sel_in),
        .strong_pu_en (strong_pu_en),
        .mode         (mode),
        .done         (done),
        .pll_bypass   (pll_bypass)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string mode_req(input logic [1:0] m);
        case (m)
            2'b00:   return "R4";
            2'b01:   return "R5";
            2'b10:   return "R6";
            default: return "R7";
        endcase
    endfunction

    // Monitor: track cycles and compare against the scoreboard on done.
    always @(negedge clk) begin
        exp_t e;
        if (!rst_n) begin
            cyc = 0;
            got = 1'b0;
            pu_rise = -1;
        end else begin
            cyc++;
            if (strong_pu_en && pu_rise < 0) pu_rise = cyc;
            if (done && !got) begin
                got = 1'b1;
                if (q.size() == 0) begin
                    chk(1'b0, "R1", "done with empty scoreboard", 1, 0);
                end else begin
                    e = q.pop_front();
                    chk(mode == e.mode, mode_req(e.mode), "mode", mode, e.mode);
                    chk(strong_pu_en == e.pu, mode_req(e.mode), "pull-up", strong_pu_en, e.pu);
                    chk(pll_bypass == (e.mode == 2'b00), "R8", "bypass", pll_bypass, e.mode == 2'b00);
                    chk(cyc >= e.lo && cyc <= e.hi, e.pu ? "R3" : "R2", "done latency", cyc, e.lo);
                    if (e.pu)
                        chk(pu_rise >= SETTLE + 1 && pu_rise <= SETTLE + 4, "R3",
                            "pull-up rise cycle", pu_rise, SETTLE + 1);
                end
            end
        end
    end

    // Driver: reset, push expectation, release, wait, then disturb inputs.
    task automatic run_case(input logic [1:0] kind);
        exp_t e;
        logic [1:0] m0;
        logic       p0;
        logic       b0;
        @(negedge clk);
        rst_n = 1'b0;
        flip = 1'b0;
        env_kind = kind;
        e.pu = (kind < 2);
        e.mode = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : (kind == 2) ? 2'b10 : 2'b11;
        e.lo = e.pu ? 2 * SETTLE + 1 : SETTLE + 1;
        e.hi = e.pu ? 2 * SETTLE + 6 : SETTLE + 4;
        q.push_back(e);
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(strong_pu_en == 1'b0, "R1", "pull-up in reset", strong_pu_en, 0);
        chk(mode == 2'b00, "R1", "mode in reset", mode, 0);
        chk(pll_bypass == 1'b0, "R1", "bypass in reset", pll_bypass, 0);
        rst_n = 1'b1;
        repeat (SETTLE) @(negedge clk);
        chk(strong_pu_en == 1'b0, "R2", "pull-up inside first window", strong_pu_en, 0);
        chk(done == 1'b0, "R2", "done inside first window", done, 0);
        chk(pll_bypass == 1'b0, "R8", "bypass before done", pll_bypass, 0);
        for (int i = 0; i < 200 && !got; i++) @(negedge clk);
        chk(got == 1'b1, "R2", "done reached", got, 1);
        m0 = mode;
        p0 = strong_pu_en;
        b0 = pll_bypass;
        flip = 1'b1;
        repeat (20) @(negedge clk);
        chk(done == 1'b1, "R9", "done held", done, 1);
        chk(mode == m0, "R9", "mode held", mode, m0);
        chk(strong_pu_en == p0, "R9", "pull-up held", strong_pu_en, p0);
        chk(pll_bypass == b0, "R8", "bypass held", pll_bypass, b0);
        flip = 1'b0;
    endtask

    initial begin
        run_case(2'd0);
        run_case(2'd1);
        run_case(2'd2);
        run_case(2'd3);
        run_case(2'd3);
        run_case(2'd0);
        run_case(2'd2);
        run_case(2'd1);
        chk(q.size() == 0, "R9", "scoreboard drained", q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule